// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is an execution unit for a processor pipeline. Each issued operation multiplies two source operands and adds the product to a 32-bit accumulator, or subtracts it. The issue stage supplies the operands through a valid/ready port. Operands are either half-words (bits [15:0]) or full words, and each is read as an unsigned integer, a signed integer or a signed fixed-point fraction (1.15 or 1.31). All products are built on one 16x16 multiplier core. A 32-bit operand is split into halves whose partial products are summed.

The datapath is three register stages deep and accepts one operation every cycle. The accumulator carries a sticky overflow flag. Each operation can also clamp the accumulator to the most positive or most negative value. The host loads and reads the accumulator through a separate port. While operations are still in flight, that port signals busy and holds issue closed until the pipeline has drained, so no access sees a stale accumulator or is lost.

Top module: `mac_unit`

## Requirements
- R1: After reset the accumulator reads 0, `ovfFlag` is 0, `busy` is 0 and `issueReady` is 1.
- R2: An operation is accepted on a rising edge where `issueValid` and `issueReady` are both 1, and one may be accepted on every edge. Its result is in the accumulator after the second following edge. A host read raised in the cycle right after that acceptance is stalled for exactly two cycles.
- R3: `opMode` selects the operand format: 2'b00 unsigned integer, 2'b01 signed integer, 2'b1x signed fraction. With `opWide`=0 only bits [15:0] of each operand are used and bits [31:16] are ignored. With `opWide`=1 all 32 bits are used.
- R4: For half-word integer operands the full exact product is accumulated, zero-extended in unsigned mode and sign-extended in signed mode.
- R5: For half-word fractions the 1.15 x 1.15 product is shifted left by one bit, so -1.0 x -1.0 gives +2^31.
- R6: For full-word integer operands only the low 32 bits of the product are kept, then sign-extended (signed mode) or zero-extended (unsigned mode).
- R7: For full-word fractions the term is bits [63:31] of the 64-bit signed product, read as a signed value. The remaining low bits are truncated toward minus infinity.
- R8: `opSub`=1 subtracts the term from the accumulator instead of adding it.
- R9: The sum is formed in signed arithmetic in all modes. If it leaves the range [-2^31, 2^31-1], `ovfFlag` is set and stays set until a host write. Without saturation the accumulator keeps the low 32 bits of the sum.
- R10: With `opSat`=1, an overflowing result is clamped to 32'h7FFFFFFF when the sum is positive and to 32'h80000000 when it is negative.
- R11: While any operation is in flight, a host read or write request raises `busy` and keeps `accRdValid` low. `busy` lasts at most two cycles while the request is held. With the pipeline empty, `accRdValid` is 1 and `accRdData` shows the accumulator.
- R12: A host write with the pipeline empty loads `accWrData` into the accumulator on the next edge and clears `ovfFlag`. A write request that is only present while `busy` is 1 has no effect.
- R13: While a host read or write is requested, `issueReady` is 0 and an asserted `issueValid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue stage offers an operation |
| issueReady | output | 1 | Unit accepts the offered operation |
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand |
| opWide | input | 1 | 1: 32-bit operands, 0: bits [15:0] only |
| opMode | input | 2 | 00 unsigned, 01 signed, 1x signed fraction |
| opSub | input | 1 | Subtract the product instead of adding |
| opSat | input | 1 | Clamp the accumulator on overflow |
| accWrEn | input | 1 | Host write request |
| accWrData | input | 32 | Host write value |
| accRdReq | input | 1 | Host read request |
| accRdValid | output | 1 | Read data valid (pipeline drained) |
| accRdData | output | 32 | Accumulator value |
| busy | output | 1 | Host access stalled by in-flight operations |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A corrupted partial product, a wrong operand extension or a wrong fraction alignment cannot be seen until the accumulator is read. It then shows up as a wrong accumulator word, usually one that differs only in its upper half or its lowest bit. A wrong overflow test shows instead as a flag that fails to set, or a missing clamp, on the read that follows. A fault in the stage-valid chain shows as a read stall of the wrong length, or as an accumulator change that is not three edges after an issue. These effects are visible within three cycles of the faulty operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // operand format selected per operation
  typedef enum logic [1:0] {
    FMT_UNSIGNED = 2'b00,
    FMT_SIGNED   = 2'b01,
    FMT_FRAC     = 2'b10,
    FMT_FRAC_ALT = 2'b11
  } opFmt_e;

  // per-operation controls carried down the pipeline
  typedef struct packed {
    logic wide;
    logic frac;
    logic signExt;
    logic sub;
    logic sat;
  } opCtl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stage1Load;
    logic stage2Load;
    logic accCommit;
    logic hostWrite;
  } macStrobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       accRdReq,
  input  logic       accWrEn,
  output logic       issueReady,
  output logic       busy,
  output logic       accRdValid,
  output macStrobe_t strobe
);

  logic stage1Valid;
  logic stage2Valid;
  logic hostReq;
  logic inFlight;
  logic fire;

  assign hostReq    = accRdReq | accWrEn;
  assign inFlight   = stage1Valid | stage2Valid;
  // host access has priority and closes issue so the pipeline drains
  assign issueReady = ~hostReq;
  assign fire       = issueValid & issueReady;
  assign busy       = hostReq & inFlight;
  assign accRdValid = accRdReq & ~inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= fire;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.stage1Load = fire;
    strobe.stage2Load = stage1Valid;
    strobe.accCommit  = stage2Valid;
    strobe.hostWrite  = accWrEn & ~inFlight;
  end

endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  macStrobe_t            strobe,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  input  logic                  opWide,
  input  logic [1:0]            opMode,
  input  logic                  opSub,
  input  logic                  opSat,
  input  logic [2*HALF_W-1:0]   accWrData,
  output logic [2*HALF_W-1:0]   accOut,
  output logic                  ovfOut
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int EXT_W  = HALF_W + 1;
  localparam int PP_W   = 2 * EXT_W;
  localparam int PROD_W = 2 * WORD_W;
  localparam int TERM_W = WORD_W + 2;
  localparam int SUM_W  = WORD_W + 3;
  localparam int NUM_PP = 4;

  // ---------------- stage 1: operand conditioning and partial products
  opCtl_t ctlIn;
  always_comb begin
    ctlIn.wide    = opWide;
    ctlIn.frac    = opMode[1];
    ctlIn.signExt = opMode[1] | opMode[0];
    ctlIn.sub     = opSub;
    ctlIn.sat     = opSat;
  end

  function automatic logic [WORD_W-1:0] widen(input logic [WORD_W-1:0] x,
                                               input logic wide,
                                               input logic signExt);
    logic fill;
    fill = signExt & x[HALF_W-1];
    return wide ? x : {{HALF_W{fill}}, x[HALF_W-1:0]};
  endfunction

  logic [WORD_W-1:0] aWord, bWord;
  logic signed [EXT_W-1:0] aPart [2];
  logic signed [EXT_W-1:0] bPart [2];

  assign aWord = widen(opA, opWide, ctlIn.signExt);
  assign bWord = widen(opB, opWide, ctlIn.signExt);

  // index 0 = low half (always zero-extended), 1 = high half (format-extended)
  assign aPart[0] = {1'b0, aWord[HALF_W-1:0]};
  assign aPart[1] = {ctlIn.signExt & aWord[WORD_W-1], aWord[WORD_W-1:HALF_W]};
  assign bPart[0] = {1'b0, bWord[HALF_W-1:0]};
  assign bPart[1] = {ctlIn.signExt & bWord[WORD_W-1], bWord[WORD_W-1:HALF_W]};

  logic signed [PP_W-1:0] ppNext [NUM_PP];
  logic signed [PP_W-1:0] ppReg  [NUM_PP];
  opCtl_t ctlS1;

  // pp index {aHalf, bHalf}: 0 lo*lo, 1 lo*hi, 2 hi*lo, 3 hi*hi
  for (genvar gi = 0; gi < NUM_PP; gi++) begin : g_pp
    assign ppNext[gi] = aPart[gi / 2] * bPart[gi % 2];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ppReg[gi] <= '0;
      end else if (strobe.stage1Load) begin
        ppReg[gi] <= ppNext[gi];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlS1 <= '0;
    end else if (strobe.stage1Load) begin
      ctlS1 <= ctlIn;
    end
  end

  // ---------------- stage 2: combine partial products, align, negate
  function automatic logic [PROD_W-1:0] extPp(input logic [PP_W-1:0] p);
    return {{(PROD_W-PP_W){p[PP_W-1]}}, p};
  endfunction

  logic [PROD_W-1:0] prodFull;
  logic [PROD_W-1:0] crossSum;
  logic [WORD_W:0]   fracBits;
  logic [WORD_W-1:0] intBits;
  logic              intFill;
  logic [TERM_W-1:0] termRaw;
  logic [TERM_W-1:0] termNext;
  logic [TERM_W-1:0] termReg;
  logic              satS2;

  always_comb begin
    crossSum = extPp(ppReg[1]) + extPp(ppReg[2]);
    prodFull = extPp(ppReg[0])
             + (crossSum << HALF_W)
             + (extPp(ppReg[3]) << WORD_W);

    // fraction: move the binary point one place left (1.15 or 1.31 layout)
    if (ctlS1.wide) begin
      fracBits = prodFull[PROD_W-1:WORD_W-1];
    end else begin
      fracBits = {prodFull[WORD_W-1:0], 1'b0};
    end

    intBits = prodFull[WORD_W-1:0];
    intFill = ctlS1.signExt & intBits[WORD_W-1];

    if (ctlS1.frac) begin
      termRaw = {fracBits[WORD_W], fracBits};
    end else begin
      termRaw = {{2{intFill}}, intBits};
    end

    termNext = ctlS1.sub ? (~termRaw + 1'b1) : termRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      termReg <= '0;
      satS2   <= 1'b0;
    end else if (strobe.stage2Load) begin
      termReg <= termNext;
      satS2   <= ctlS1.sat;
    end
  end

  // ---------------- stage 3: accumulate, overflow detect, clamp
  logic [WORD_W-1:0] accReg;
  logic              ovfReg;
  logic [SUM_W-1:0]  sumWide;
  logic [SUM_W-WORD_W:0] sumTop;
  logic              sumOvf;
  logic [WORD_W-1:0] clampVal;
  logic [WORD_W-1:0] accNext;

  always_comb begin
    sumWide = {{(SUM_W-TERM_W){termReg[TERM_W-1]}}, termReg}
            + {{(SUM_W-WORD_W){accReg[WORD_W-1]}}, accReg};
    sumTop  = sumWide[SUM_W-1:WORD_W-1];
    sumOvf  = ~((&sumTop) | ~(|sumTop));
    clampVal = sumWide[SUM_W-1] ? {1'b1, {(WORD_W-1){1'b0}}}
                                : {1'b0, {(WORD_W-1){1'b1}}};
    accNext = (sumOvf && satS2) ? clampVal : sumWide[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      ovfReg <= 1'b0;
    end else if (strobe.hostWrite) begin
      accReg <= accWrData;
      ovfReg <= 1'b0;
    end else if (strobe.accCommit) begin
      accReg <= accNext;
      ovfReg <= ovfReg | sumOvf;
    end
  end

  assign accOut = accReg;
  assign ovfOut = ovfReg;

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  output logic                issueReady,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                opWide,
  input  logic [1:0]          opMode,
  input  logic                opSub,
  input  logic                opSat,
  input  logic                accWrEn,
  input  logic [2*HALF_W-1:0] accWrData,
  input  logic                accRdReq,
  output logic                accRdValid,
  output logic [2*HALF_W-1:0] accRdData,
  output logic                busy,
  output logic                ovfFlag
);

  macStrobe_t strobe;

  mac_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .accRdReq   (accRdReq),
    .accWrEn    (accWrEn),
    .issueReady (issueReady),
    .busy       (busy),
    .accRdValid (accRdValid),
    .strobe     (strobe)
  );

  mac_dpath #(.HALF_W(HALF_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .opWide    (opWide),
    .opMode    (opMode),
    .opSub     (opSub),
    .opSat     (opSat),
    .accWrData (accWrData),
    .accOut    (accRdData),
    .ovfOut    (ovfFlag)
  );

endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                issueValid,
  input logic                issueReady,
  input logic                accWrEn,
  input logic [2*HALF_W-1:0] accWrData,
  input logic                accRdReq,
  input logic                accRdValid,
  input logic [2*HALF_W-1:0] accRdData,
  input logic                busy,
  input logic                ovfFlag
);

  // R2
  acc_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(accRdData) |-> ($past(issueValid && issueReady, 3) || $past(accWrEn && !busy)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(accWrEn && !busy)) |=> ovfFlag);

  // R11
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);

  // R11
  rd_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accRdValid && busy));

  // R12
  host_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accWrEn && !busy) |=> (accRdData == $past(accWrData)) && !ovfFlag);

endmodule

bind mac_unit mac_chk #(.HALF_W(HALF_W)) i_mac_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .accWrEn    (accWrEn),
  .accWrData  (accWrData),
  .accRdReq   (accRdReq),
  .accRdValid (accRdValid),
  .accRdData  (accRdData),
  .busy       (busy),
  .ovfFlag    (ovfFlag)
);

// File: tb/test_mac_unit.sv
module test_mac_unit;

  typedef struct packed {
    logic [31:0] init;
    logic [31:0] a;
    logic [31:0] b;
    logic        wide;
    logic [1:0]  mode;
    logic        sub;
    logic        sat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_FFFE, 32'h0000_0003, 1'b0, 2'b01, 1'b0, 1'b0}, // R4 signed -2*3
    '{32'h0000_0000, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 unsigned max, R9 wraps
    '{32'h0000_0000, 32'h1234_0005, 32'hABCD_0007, 1'b0, 2'b01, 1'b0, 1'b0}, // R3 high bits ignored
    '{32'h0000_0000, 32'h0000_4000, 32'h0000_4000, 1'b0, 2'b10, 1'b0, 1'b0}, // R5 0.5*0.5
    '{32'h0000_0000, 32'h0000_8000, 32'h0000_8000, 1'b0, 2'b11, 1'b0, 1'b0}, // R5 -1*-1 overflow
    '{32'h0000_0000, 32'h0000_8000, 32'h0000_8000, 1'b0, 2'b10, 1'b0, 1'b1}, // R10 clamp positive
    '{32'h0000_0010, 32'h0001_2345, 32'hFFFF_FFFE, 1'b1, 2'b01, 1'b0, 1'b0}, // R6 signed wide
    '{32'h0000_0000, 32'h8000_0001, 32'h0000_0003, 1'b1, 2'b00, 1'b0, 1'b0}, // R6 unsigned wide
    '{32'h0000_0000, 32'h4000_0000, 32'h4000_0000, 1'b1, 2'b10, 1'b0, 1'b0}, // R7 0.5*0.5
    '{32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 2'b10, 1'b0, 1'b0}, // R7 -1*-1 overflow
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h4000_0000, 1'b1, 2'b10, 1'b0, 1'b0}, // R7 floor truncation
    '{32'h0000_0064, 32'h0000_0003, 32'h0000_0004, 1'b0, 2'b01, 1'b1, 1'b0}, // R8 subtract
    '{32'h8000_0010, 32'h0000_0100, 32'h0000_0100, 1'b0, 2'b01, 1'b1, 1'b1}, // R10 clamp negative
    '{32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 2'b01, 1'b0, 1'b0}, // R9 wrap
    '{32'h0000_0000, 32'h0000_8000, 32'h0000_0002, 1'b0, 2'b00, 1'b0, 1'b0}  // R3 unsigned reading
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueReady;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        opWide = 1'b0;
  logic [1:0]  opMode = '0;
  logic        opSub = 1'b0;
  logic        opSat = 1'b0;
  logic        accWrEn = 1'b0;
  logic [31:0] accWrData = '0;
  logic        accRdReq = 1'b0;
  logic        accRdValid;
  logic [31:0] accRdData;
  logic        busy;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_unit i_mac_unit (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueReady (issueReady),
    .opA        (opA),
    .opB        (opB),
    .opWide     (opWide),
    .opMode     (opMode),
    .opSub      (opSub),
    .opSat      (opSat),
    .accWrEn    (accWrEn),
    .accWrData  (accWrData),
    .accRdReq   (accRdReq),
    .accRdValid (accRdValid),
    .accRdData  (accRdData),
    .busy       (busy),
    .ovfFlag    (ovfFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference computed from the requirements
  task automatic model(input vec_t v, input logic [31:0] accIn,
                       output logic [31:0] accOut, output logic ovf);
    longint sa, sb, p, t, s;
    logic [31:0] low;
    if (v.mode[1]) begin
      if (!v.wide) begin
        sa = longint'($signed(v.a[15:0]));
        sb = longint'($signed(v.b[15:0]));
        t  = sa * sb * 2;
      end else begin
        sa = longint'($signed(v.a));
        sb = longint'($signed(v.b));
        t  = (sa * sb) >>> 31;
      end
    end else begin
      if (!v.wide) begin
        sa = v.mode[0] ? longint'($signed(v.a[15:0])) : longint'({48'd0, v.a[15:0]});
        sb = v.mode[0] ? longint'($signed(v.b[15:0])) : longint'({48'd0, v.b[15:0]});
        t  = sa * sb;
      end else begin
        sa = v.mode[0] ? longint'($signed(v.a)) : longint'({32'd0, v.a});
        sb = v.mode[0] ? longint'($signed(v.b)) : longint'({32'd0, v.b});
        p  = sa * sb;
        low = p[31:0];
        t  = v.mode[0] ? longint'($signed(low)) : longint'({32'd0, low});
      end
    end
    if (v.sub) t = -t;
    s = longint'($signed(accIn)) + t;
    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (ovf && v.sat) accOut = (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else accOut = s[31:0];
  endtask

  task automatic hostWrite(input logic [31:0] val);
    @(negedge clk);
    accWrEn = 1'b1;
    accWrData = val;
    #1;
    while (busy) @(negedge clk);
    @(negedge clk);
    accWrEn = 1'b0;
  endtask

  task automatic setOp(input vec_t v);
    opA = v.a; opB = v.b; opWide = v.wide; opMode = v.mode;
    opSub = v.sub; opSat = v.sat;
  endtask

  task automatic issueOne(input vec_t v);
    @(negedge clk);
    setOp(v);
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  // raises a read at the current negedge, waits out busy, returns data
  task automatic hostRead(output logic [31:0] data, output logic ovf, output int stalls);
    accRdReq = 1'b1;
    stalls = 0;
    #1;
    while (busy && stalls < 10) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    chk("R11 accRdValid when drained", {31'd0, accRdValid}, 32'd1);
    data = accRdData;
    ovf = ovfFlag;
    @(negedge clk);
    accRdReq = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, expAcc, accRun;
    logic rdOvf, expOvf, ovfRun, stepOvf;
    int stalls;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 issueReady", {31'd0, issueReady}, 32'd1);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ovfFlag", {31'd0, ovfFlag}, 32'd0);
    hostRead(rd, rdOvf, stalls);
    chk("R1 accumulator", rd, 32'd0);
    chk("R1 no stall", stalls, 32'd0);

    // table walk: load, issue, read right after issue
    for (int i = 0; i < NV; i++) begin
      hostWrite(VECS[i].init);
      issueOne(VECS[i]);
      hostRead(rd, rdOvf, stalls);
      model(VECS[i], VECS[i].init, expAcc, expOvf);
      $display("vector %0d", i);
      chk("R3-R10 accumulator", rd, expAcc);
      chk("R9 overflow flag", {31'd0, rdOvf}, {31'd0, expOvf});
      chk("R2 read stall after issue", stalls, 32'd2);
    end

    // R2 back-to-back issue, one per cycle
    hostWrite(32'h0000_0000);
    accRun = 32'h0000_0000;
    ovfRun = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      setOp(VECS[i]);
      issueValid = 1'b1;
      #1;
      chk("R2 issueReady while streaming", {31'd0, issueReady}, 32'd1);
      model(VECS[i], accRun, expAcc, stepOvf);
      accRun = expAcc;
      ovfRun = ovfRun | stepOvf;
      @(negedge clk);
    end
    issueValid = 1'b0;
    hostRead(rd, rdOvf, stalls);
    chk("R2 streamed accumulator", rd, accRun);
    chk("R9 streamed sticky overflow", {31'd0, rdOvf}, {31'd0, ovfRun});
    chk("R2 streamed stall", stalls, 32'd2);

    // R9 sticky across a later non-overflowing operation
    hostWrite(32'h7FFF_FFFF);
    issueOne(VECS[13]);
    issueOne(VECS[13]);
    hostRead(rd, rdOvf, stalls);
    chk("R9 sticky flag", {31'd0, rdOvf}, 32'd1);
    chk("R9 wrapped value", rd, 32'h8000_0001);

    // R12 write clears flag
    hostWrite(32'h0000_0005);
    @(negedge clk);
    chk("R12 flag cleared", {31'd0, ovfFlag}, 32'd0);
    hostRead(rd, rdOvf, stalls);
    chk("R12 loaded value", rd, 32'h0000_0005);

    // R12 write held only while busy has no effect
    hostWrite(32'h0000_000A);
    issueOne('{32'd0, 32'd2, 32'd3, 1'b0, 2'b01, 1'b0, 1'b0});
    accWrEn = 1'b1;
    accWrData = 32'h0000_0055;
    #1;
    chk("R11 busy on write during flight", {31'd0, busy}, 32'd1);
    @(negedge clk);
    accWrEn = 1'b0;
    repeat (3) @(negedge clk);
    hostRead(rd, rdOvf, stalls);
    chk("R12 busy write ignored", rd, 32'h0000_0010);

    // R13 issue ignored while host access requested
    accRdReq = 1'b1;
    setOp('{32'd0, 32'd1, 32'd1, 1'b0, 2'b01, 1'b0, 1'b0});
    issueValid = 1'b1;
    #1;
    chk("R13 issueReady low", {31'd0, issueReady}, 32'd0);
    @(negedge clk);
    issueValid = 1'b0;
    accRdReq = 1'b0;
    repeat (4) @(negedge clk);
    hostRead(rd, rdOvf, stalls);
    chk("R13 blocked issue had no effect", rd, 32'h0000_0010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule